// File: doc/BRIEF.md
# NAND Sequential Cache Read Controller

This controller sits on the host side of a NAND flash device. It reads a run of consecutive pages from one erase block and delivers them as a byte stream. It uses the device's cache register so that the array fetch of the next page runs while the current page is being shifted out. A request gives a start row address, a page count and a page length in bytes. The controller first opens the run with a plain page read. It then steps through the run with cache-continue commands and closes it with a cache-end command that starts no further fetch. Between steps it waits on the device ready/busy line.

The device side is an abstract synchronous bus. In each clock cycle the controller presents one bus operation with its outgoing byte: idle, command, address, or read. For a read, the device returns a byte on `nand_io_in` in the same cycle and advances its column pointer at the clock edge. The consumer side is a valid/ready byte stream. A page-end flag marks the final byte of each page.

A request whose pages would leave the block is refused with a one-cycle `reject` pulse, and no bus activity follows. Requests with a zero count or a zero length are refused the same way.

Top module: `nand_cache_reader`

## Requirements
- R1: While reset is held and after its release with no request, `busy`, `reject` and `out_valid` are 0 and `nand_op` is 0 (idle). The bus operation encoding is 0 idle, 1 command, 2 address, 3 read.
- R2: A request is refused when the page count is 0, when the page length is 0, or when the low log2(PAGES_PER_BLK) bits of the start row plus the count exceed PAGES_PER_BLK. A refusal raises `reject` for exactly the cycle after `start` is sampled, leaves `busy` at 0 and puts no operation on the bus.
- R3: An accepted request begins with command 00h. Five address cycles follow in this order: two column bytes, both 0, then the row's low, middle and high bytes. Then comes command 30h.
- R4: After a 30h, 31h or 3Fh command, the controller waits WB_CYC cycles. It issues no further bus operation until `nand_rb_n` is high.
- R5: For a count of 1, no 31h or 3Fh command is issued. The page is streamed straight after the 30h busy period.
- R6: For a count N > 1, exactly N-1 commands 31h and then one 3Fh are issued. Exactly N pages are streamed, in ascending row order, with each byte equal to what the device returns.
- R7: Every page delivers exactly `page_len` bytes, and `out_last` is 1 on the last byte of each page and on no other byte.
- R8: A read operation is issued in exactly the cycles where a byte is accepted (`out_valid` and `out_ready`). While `out_valid` is high and `out_ready` is low, the offered byte position holds.
- R9: A 31h or 3Fh command is issued only after the last byte of the preceding page has been accepted. No command appears while a byte is being offered.
- R10: A `start` pulse while `busy` is high is ignored and does not alter the run in progress.
- R11: A run that ends exactly on the last page of a block (offset plus count equal to PAGES_PER_BLK) is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| start_row | input | ROW_W | Row address of the first page |
| page_cnt | input | CNT_W | Number of pages in the run |
| page_len | input | COL_W | Bytes per page |
| busy | output | 1 | A run is in progress |
| reject | output | 1 | One-cycle pulse: request refused |
| nand_op | output | 2 | Bus operation: 0 idle, 1 command, 2 address, 3 read |
| nand_io_out | output | 8 | Command or address byte |
| nand_io_in | input | 8 | Read data from the device |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |
| out_valid | output | 1 | Stream byte offered |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Last byte of the current page |
| out_ready | input | 1 | Consumer accepts the offered byte |

## Verification
The bench aims at the block edge. A run that ends on the final page of a block must be accepted, and a run one page past it must be refused. Getting the offset sum wrong either truncates legal runs or reads into the next block. It also varies the device fetch time against page length and consumer stalls, so that a 31h arrives while the previous fetch is still running. A controller that polls ready too early or reads during busy is caught by the device model. Single-page runs must carry no cache commands, and multi-page runs must carry exactly one closing 3Fh. An off-by-one in the cache-command count shows up as a missing or extra page in the scoreboard. A stray `start` in mid-run checks that a second 00h is never issued.

// File: rtl/nscr_pkg.sv
// Package: shared bus operation codes, device opcodes and sequencer
// states for the NAND cache read controller.
package nscr_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_CMD  = 2'd1,
        BUS_ADDR = 2'd2,
        BUS_READ = 2'd3
    } bus_op_e;

    localparam logic [7:0] OPC_READ_SETUP = 8'h00;
    localparam logic [7:0] OPC_READ_GO    = 8'h30;
    localparam logic [7:0] OPC_CACHE_NEXT = 8'h31;
    localparam logic [7:0] OPC_CACHE_END  = 8'h3F;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_ADDR,
        SQ_GO,
        SQ_WAIT,
        SQ_CACHE,
        SQ_STREAM
    } seq_state_e;

endpackage

// File: rtl/nscr_range_chk.sv
// Module: nscr_range_chk
// Decides whether a request is legal. The count and the length must be
// non-zero, and the run must stay inside one block.
// Assumes PAGES_PER_BLK is a power of two of at least 2, so the page
// offset inside the block is the low bits of the row address.
module nscr_range_chk #(
    parameter int PAGES_PER_BLK = 64,
    parameter int CNT_W         = 8,
    parameter int COL_W         = 12,
    localparam int PG_W         = $clog2(PAGES_PER_BLK)
) (
    input  logic [PG_W-1:0]  blk_offset,
    input  logic [CNT_W-1:0] req_cnt,
    input  logic [COL_W-1:0] req_len,
    output logic             req_ok
);
    localparam int SUM_W = ((CNT_W > PG_W) ? CNT_W : PG_W) + 1;

    logic [SUM_W-1:0] end_page;

    // End page index (exclusive) of the requested run.
    always_comb end_page = SUM_W'(blk_offset) + SUM_W'(req_cnt);

    // Legal when non-empty and not running past the block end.
    always_comb req_ok = (req_cnt != '0) && (req_len != '0) &&
                         (end_page <= SUM_W'(PAGES_PER_BLK));
endmodule

// File: rtl/nscr_page_stream.sv
// Module: nscr_page_stream
// Counts the bytes of one page on the output stream and flags the last
// one. A read strobe to the device is raised exactly when a byte is
// accepted. Assumes page_len is non-zero and stable while en is high.
module nscr_page_stream #(
    parameter int COL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [COL_W-1:0] page_len,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             out_last,
    output logic             rd_strobe,
    output logic             page_done
);
    logic [COL_W-1:0] col_q;

    // Offer a byte whenever the sequencer is in its streaming phase.
    always_comb out_valid = en;

    // Mark the final byte position of the page.
    always_comb out_last = en && (col_q == page_len - COL_W'(1));

    // Pull one byte from the device on every accepted transfer.
    always_comb rd_strobe = en && out_ready;

    // Page completes when its last byte is accepted.
    always_comb page_done = rd_strobe && out_last;

    // Byte position inside the page; restarts for each page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (!en || page_done) begin
            col_q <= '0;
        end else if (rd_strobe) begin
            col_q <= col_q + COL_W'(1);
        end
    end
endmodule

// File: rtl/nscr_cmd_seq.sv
// Module: nscr_cmd_seq
// Command sequencer. It issues the opening page read (setup command,
// address cycles, go command), then one cache command per extra page,
// waits on ready/busy after each confirm, and hands each page to the
// stream counter. Assumes req_ok is already qualified for the request.
module nscr_cmd_seq
    import nscr_pkg::*;
#(
    parameter int ROW_W     = 24,
    parameter int CNT_W     = 8,
    parameter int COL_BYTES = 2,
    parameter int WB_CYC    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             req_ok,
    input  logic [ROW_W-1:0] req_row,
    input  logic [CNT_W-1:0] req_cnt,
    input  logic             nand_rb_n,
    input  logic             page_done,
    output logic             busy,
    output logic             req_taken,
    output logic             stream_en,
    output logic [1:0]       bus_op,
    output logic [7:0]       bus_dout
);
    localparam int ROW_BYTES = (ROW_W + 7) / 8;
    localparam int ADDR_CYC  = COL_BYTES + ROW_BYTES;
    localparam int IDX_W     = $clog2(ADDR_CYC);
    localparam int WB_W      = $clog2(WB_CYC + 1);

    seq_state_e             state, state_n;
    logic [ROW_W-1:0]       row_q;
    logic [ROW_BYTES*8-1:0] row_pad;
    logic [CNT_W-1:0]       left_q;
    logic [IDX_W-1:0]       idx_q;
    logic [WB_W-1:0]        wait_q;
    logic                   cached_q;
    logic [7:0]             addr_byte;

    // A request is taken only while idle and legal.
    always_comb req_taken = start && (state == SQ_IDLE) && req_ok;

    // Busy for every state except idle.
    always_comb busy = (state != SQ_IDLE);

    // Row widened to whole bytes for the address cycles.
    always_comb row_pad = (ROW_BYTES*8)'(row_q);

    // Byte for the current address cycle: zero column, then row low to high.
    always_comb begin
        addr_byte = 8'h00;
        for (int b = 0; b < ROW_BYTES; b++) begin
            if (idx_q == IDX_W'(COL_BYTES + b)) addr_byte = row_pad[b*8 +: 8];
        end
    end

    // Next state and bus drive for each sequencer phase.
    always_comb begin
        state_n   = state;
        bus_op    = BUS_IDLE;
        bus_dout  = 8'h00;
        stream_en = 1'b0;
        case (state)
            SQ_IDLE: begin
                if (req_taken) state_n = SQ_SETUP;
            end
            SQ_SETUP: begin
                bus_op   = BUS_CMD;
                bus_dout = OPC_READ_SETUP;
                state_n  = SQ_ADDR;
            end
            SQ_ADDR: begin
                bus_op   = BUS_ADDR;
                bus_dout = addr_byte;
                if (idx_q == IDX_W'(ADDR_CYC - 1)) state_n = SQ_GO;
            end
            SQ_GO: begin
                bus_op   = BUS_CMD;
                bus_dout = OPC_READ_GO;
                state_n  = SQ_WAIT;
            end
            SQ_WAIT: begin
                if ((wait_q == '0) && nand_rb_n) begin
                    if (!cached_q && (left_q != '0)) state_n = SQ_CACHE;
                    else                             state_n = SQ_STREAM;
                end
            end
            SQ_CACHE: begin
                bus_op   = BUS_CMD;
                bus_dout = (left_q == CNT_W'(1)) ? OPC_CACHE_END : OPC_CACHE_NEXT;
                state_n  = SQ_WAIT;
            end
            SQ_STREAM: begin
                stream_en = 1'b1;
                if (page_done) state_n = (left_q == '0) ? SQ_IDLE : SQ_CACHE;
            end
            default: state_n = SQ_IDLE;
        endcase
    end

    // State register plus the per-phase counters and request latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            row_q    <= '0;
            left_q   <= '0;
            idx_q    <= '0;
            wait_q   <= '0;
            cached_q <= 1'b0;
        end else begin
            state <= state_n;
            case (state)
                SQ_IDLE: begin
                    if (req_taken) begin
                        row_q    <= req_row;
                        left_q   <= (req_cnt == CNT_W'(1)) ? '0 : req_cnt;
                        cached_q <= 1'b0;
                    end
                end
                SQ_SETUP: idx_q  <= '0;
                SQ_ADDR:  idx_q  <= idx_q + IDX_W'(1);
                SQ_GO:    wait_q <= WB_W'(WB_CYC);
                SQ_WAIT: begin
                    if (wait_q != '0) wait_q <= wait_q - WB_W'(1);
                end
                SQ_CACHE: begin
                    left_q   <= left_q - CNT_W'(1);
                    cached_q <= 1'b1;
                    wait_q   <= WB_W'(WB_CYC);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nand_cache_reader.sv
// Module: nand_cache_reader (top)
// Streams a run of consecutive pages from one NAND block, using cache
// read commands so that array fetches overlap with byte output.
// Assumes the device returns read data combinationally on nand_io_in
// during a read cycle and drops nand_rb_n within WB_CYC cycles of a
// confirm command. PAGES_PER_BLK must be a power of two.
module nand_cache_reader #(
    parameter int ROW_W         = 24,
    parameter int CNT_W         = 8,
    parameter int COL_W         = 12,
    parameter int PAGES_PER_BLK = 64,
    parameter int WB_CYC        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] start_row,
    input  logic [CNT_W-1:0] page_cnt,
    input  logic [COL_W-1:0] page_len,
    output logic             busy,
    output logic             reject,
    output logic [1:0]       nand_op,
    output logic [7:0]       nand_io_out,
    input  logic [7:0]       nand_io_in,
    input  logic             nand_rb_n,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             out_ready
);
    import nscr_pkg::*;

    localparam int PG_W = $clog2(PAGES_PER_BLK);

    logic             req_ok, req_taken, stream_en;
    logic             rd_strobe, page_done;
    logic [1:0]       seq_op;
    logic [COL_W-1:0] len_q;
    logic             reject_q;

    nscr_range_chk #(
        .PAGES_PER_BLK(PAGES_PER_BLK),
        .CNT_W(CNT_W),
        .COL_W(COL_W)
    ) u_range (
        .blk_offset(start_row[PG_W-1:0]),
        .req_cnt   (page_cnt),
        .req_len   (page_len),
        .req_ok    (req_ok)
    );

    nscr_cmd_seq #(
        .ROW_W(ROW_W),
        .CNT_W(CNT_W),
        .COL_BYTES(2),
        .WB_CYC(WB_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .req_ok   (req_ok),
        .req_row  (start_row),
        .req_cnt  (page_cnt),
        .nand_rb_n(nand_rb_n),
        .page_done(page_done),
        .busy     (busy),
        .req_taken(req_taken),
        .stream_en(stream_en),
        .bus_op   (seq_op),
        .bus_dout (nand_io_out)
    );

    nscr_page_stream #(
        .COL_W(COL_W)
    ) u_stream (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (stream_en),
        .page_len (len_q),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_last (out_last),
        .rd_strobe(rd_strobe),
        .page_done(page_done)
    );

    // Hold the page length of the accepted request for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n)         len_q <= '0;
        else if (req_taken) len_q <= page_len;
    end

    // One-cycle refusal pulse for an illegal request seen while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) reject_q <= 1'b0;
        else        reject_q <= start && !busy && !req_ok;
    end

    // A read strobe takes over the bus; otherwise the sequencer drives it.
    always_comb nand_op = rd_strobe ? 2'(BUS_READ) : seq_op;

    // Stream bytes pass straight from the device bus.
    always_comb out_data = nand_io_in;
    always_comb reject   = reject_q;
endmodule

// File: rtl/nscr_checks.sv
// Module: nscr_checks
// Port-level protocol properties for nand_cache_reader, attached by bind.
module nscr_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       reject,
    input logic [1:0] nand_op,
    input logic [7:0] nand_io_out,
    input logic       nand_rb_n,
    input logic       out_valid,
    input logic       out_last,
    input logic       out_ready
);
    logic cache_cmd;

    // A cache command (31h or 3Fh) on the bus.
    always_comb cache_cmd = (nand_op == 2'd1) &&
                            ((nand_io_out == 8'h31) || (nand_io_out == 8'h3F));

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_op == 2'd0) && !out_valid);

    assert_reject_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> $past(start) && !busy);

    assert_reject_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> !reject);

    assert_ready_before_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((nand_op == 2'd3) || cache_cmd) |-> nand_rb_n);

    assert_last_in_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_last));

    assert_no_cmd_while_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (nand_op != 2'd1));
endmodule

bind nand_cache_reader nscr_checks u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .reject     (reject),
    .nand_op    (nand_op),
    .nand_io_out(nand_io_out),
    .nand_rb_n  (nand_rb_n),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .out_ready  (out_ready)
);

// File: tb/nand_cache_reader_tb.sv
// Bench: scoreboard around nand_cache_reader with a behavioural cache-read
// device model; the run task queues expected bytes, the monitor pops them.
module nand_cache_reader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_row = '0;
    logic [7:0]  page_cnt = '0;
    logic [11:0] page_len = '0;
    logic        out_ready = 1'b0;
    logic        busy, reject, out_valid, out_last, nand_rb_n;
    logic [1:0]  nand_op;
    logic [7:0]  nand_io_out, nand_io_in, out_data;

    always #10 clk = ~clk;

    nand_cache_reader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_row(start_row),
        .page_cnt(page_cnt), .page_len(page_len), .busy(busy), .reject(reject),
        .nand_op(nand_op), .nand_io_out(nand_io_out), .nand_io_in(nand_io_in),
        .nand_rb_n(nand_rb_n), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_ready(out_ready)
    );

    function automatic logic [7:0] pat(input logic [23:0] r, input int c);
        return (r[7:0] * 8'd13) ^ r[15:8] ^ 8'(c * 7);
    endfunction

    // ---------------- device model ----------------
    int          tr_cyc = 20;
    int          cur_len = 1;
    logic [7:0]  ab [5];
    int          an = 0;
    logic [23:0] dreg_row = '0, cache_row = '0;
    int          col = 0, fetch_t = 0, copy_t = 0;
    logic        plain = 1'b0, pend = 1'b0, is31 = 1'b0;
    int          n00 = 0, n30 = 0, n31 = 0, n3f = 0, rc = 0, acc0 = 0;
    int          mdl_chk = 0, mdl_bad = 0;
    int          acc = 0;

    assign nand_rb_n  = !(plain || pend || (copy_t != 0));
    assign nand_io_in = pat(cache_row, col);

    always @(posedge clk) begin
        if (nand_op != 2'd0) begin
            mdl_chk++;
            if (!nand_rb_n) begin
                mdl_bad++;
                $display("FAIL R4 bus op while device busy: actual op=%0d expected no op", nand_op);
            end
        end
        if (fetch_t > 0) fetch_t <= fetch_t - 1;
        if (copy_t > 0)  copy_t  <= copy_t - 1;
        if (plain && fetch_t == 0) begin
            cache_row <= dreg_row; col <= 0; plain <= 1'b0;
        end
        if (pend && fetch_t == 0) begin
            cache_row <= dreg_row; col <= 0; pend <= 1'b0; copy_t <= 3;
            if (is31) begin dreg_row <= dreg_row + 24'd1; fetch_t <= tr_cyc; end
        end
        case (nand_op)
            2'd1: begin
                case (nand_io_out)
                    8'h00: begin n00++; an <= 0; rc <= 0; acc0 <= acc; end
                    8'h30: begin
                        n30++;
                        dreg_row <= {ab[4], ab[3], ab[2]};
                        fetch_t <= tr_cyc; plain <= 1'b1;
                    end
                    8'h31, 8'h3F: begin
                        if (nand_io_out == 8'h31) n31++; else n3f++;
                        mdl_chk++;
                        if ((acc - acc0) != rc * cur_len) begin
                            mdl_bad++;
                            $display("FAIL R9 cache command before page drained: actual bytes=%0d expected=%0d",
                                     acc - acc0, rc * cur_len);
                        end
                        rc <= rc + 1; pend <= 1'b1; is31 <= (nand_io_out == 8'h31);
                    end
                    default: begin
                        mdl_bad++; mdl_chk++;
                        $display("FAIL R3 unknown command: actual=%0h expected=00/30/31/3F", nand_io_out);
                    end
                endcase
            end
            2'd2: begin if (an < 5) ab[an] <= nand_io_out; an <= an + 1; end
            2'd3: col <= col + 1;
            default: ;
        endcase
    end

    // ---------------- consumer / scoreboard ----------------
    logic [8:0] exp_q [$];
    int mon_chk = 0, mon_bad = 0;
    int bp_mode = 0;

    initial begin
        forever begin
            @(posedge clk); #2;
            case (bp_mode)
                0: out_ready = 1'b1;
                1: out_ready = ($urandom % 3) != 0;
                default: out_ready = ($urandom % 4) == 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            mon_chk++;
            acc++;
            if (exp_q.size() == 0) begin
                mon_bad++;
                $display("FAIL R6 unexpected byte: actual=%0h expected none", out_data);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                if ({out_last, out_data} !== e) begin
                    mon_bad++;
                    $display("FAIL R6 R7 stream byte: actual last=%0b data=%0h expected last=%0b data=%0h",
                             out_last, out_data, e[8], e[7:0]);
                end
            end
        end
    end

    // ---------------- checks and tasks ----------------
    int chk = 0, bad = 0;
    bit fin = 0;

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        chk++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [23:0] row, input int n, input int len, input bit poke, input string req);
        int b00, b30, b31, b3f, bacc, cyc;
        b00 = n00; b30 = n30; b31 = n31; b3f = n3f; bacc = acc;
        cur_len = len;
        for (int p = 0; p < n; p++)
            for (int c = 0; c < len; c++)
                exp_q.push_back({(c == len - 1), pat(row + 24'(p), c)});
        @(negedge clk);
        start = 1'b1; start_row = row; page_cnt = 8'(n); page_len = 12'(len);
        @(negedge clk);
        start = 1'b0;
        check_eq(req, "busy after accepted start", busy, 1);
        cyc = 0;
        while (busy) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 15) begin
                start_row = 24'h0000AB; page_cnt = 8'd1; page_len = 12'd2; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check_eq(req, "bytes left in scoreboard", exp_q.size(), 0);
        check_eq("R6", "bytes accepted", acc - bacc, n * len);
        check_eq(poke ? "R10" : "R3", "setup commands", n00 - b00, 1);
        check_eq("R3", "go commands", n30 - b30, 1);
        check_eq(n > 1 ? "R6" : "R5", "cache-next commands", n31 - b31, (n > 1) ? n - 1 : 0);
        check_eq(n > 1 ? "R6" : "R5", "cache-end commands", n3f - b3f, (n > 1) ? 1 : 0);
        check_eq("R3", "address cycles", an, 5);
        check_eq("R3", "column bytes", {ab[1], ab[0]}, 0);
        check_eq("R3", "row bytes", {ab[4], ab[3], ab[2]}, row);
        @(negedge clk);
        check_eq(poke ? "R10" : "R1", "idle after run", busy, 0);
    endtask

    task automatic refuse(input logic [23:0] row, input int n, input int len);
        int b00;
        b00 = n00;
        @(negedge clk);
        start = 1'b1; start_row = row; page_cnt = 8'(n); page_len = 12'(len);
        @(negedge clk);
        start = 1'b0;
        check_eq("R2", "reject pulse", reject, 1);
        check_eq("R2", "busy on refusal", busy, 0);
        @(negedge clk);
        check_eq("R2", "reject single cycle", reject, 0);
        repeat (5) @(negedge clk);
        check_eq("R2", "bus commands after refusal", n00 - b00, 0);
        check_eq("R2", "busy stays low", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1", "busy in reset", busy, 0);
        check_eq("R1", "out_valid in reset", out_valid, 0);
        check_eq("R1", "nand_op in reset", nand_op, 0);
        check_eq("R1", "reject in reset", reject, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R1", "busy after reset", busy, 0);
        check_eq("R1", "nand_op after reset", nand_op, 0);

        tr_cyc = 20; bp_mode = 0; run(24'h000105, 1, 8, 0, "R5");
        bp_mode = 1;              run(24'h000200, 3, 5, 0, "R6");
        tr_cyc = 40; bp_mode = 0; run(24'h00013C, 4, 3, 0, "R11");
        tr_cyc = 5;  bp_mode = 2; run(24'h000340, 2, 6, 0, "R8");
        refuse(24'h00013D, 4, 4);
        refuse(24'h000000, 0, 4);
        refuse(24'h000000, 2, 0);
        tr_cyc = 12; bp_mode = 1; run(24'h010400, 3, 16, 1, "R10");
        bp_mode = 0;              run(24'h00023F, 1, 4, 0, "R11");
        tr_cyc = 3;  bp_mode = 1; run(24'h000480, 5, 2, 0, "R7");

        fin = 1;
        $display("test done: total=%0d bad=%0d", chk + mon_chk + mdl_chk, bad + mon_bad + mdl_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", chk + mon_chk + mdl_chk + 1, bad + mon_bad + mdl_bad + 1);
            $finish;
        end
    end
endmodule